// File: doc/BRIEF.md
# DRAM Rank Refresh Scheduler

This block keeps one DRAM rank refreshed. An interval timer marks out the average spacing between refresh commands. Each mark adds one owed refresh. While at least one refresh is owed and the rank is idle, the block raises a request toward the command scheduler. When the scheduler grants the request, the block holds the rank busy for the full refresh time. One command refreshes a group of consecutive rows in every bank at once, so the busy time is the rows per bank per command multiplied by the per-row refresh time. When the busy time ends, the shared row pointer moves on by one group.

The scheduler may put off a refresh to serve normal traffic. The block counts the refreshes it still owes. Once that count reaches a set ceiling, the next refresh starts without a grant, which bounds how late any row can be refreshed. With the default parameters and a 200 MHz clock, the block issues one command every 7.8 us. Each command covers 8 rows in each bank and keeps the rank busy for 320 ns. A bank of 65536 rows is therefore covered in 8192 commands, about 64 ms.

Top module: `rfsh_sched`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `ref_req` and `rank_busy` are 0 and `row_ptr` is 0.
- R2: The owed count grows by one every `REF_INTERVAL_CYC` cycles. The first growth lands on the `REF_INTERVAL_CYC`-th rising edge after reset release, so `ref_req` first reads 1 in the cycle after that edge, provided no earlier refresh was forced.
- R3: `ref_req` is 1 exactly when the owed count is nonzero and the rank is not busy. It stays high across cycles with no grant until a refresh starts.
- R4: A refresh starts on an edge where `ref_req` and `ref_gnt` are both 1. `rank_busy` is 1 from the next cycle on, for exactly `ROWS_PER_BANK_CMD * ROW_REF_CYC` cycles, and each start removes one owed refresh.
- R5: `ref_req` is 0 in every cycle where `rank_busy` is 1.
- R6: `row_ptr` changes only in the cycle where `rank_busy` falls, and then it grows by `ROWS_PER_BANK_CMD`.
- R7: After the group that starts at `BANK_ROWS - ROWS_PER_BANK_CMD`, `row_ptr` wraps to 0. `row_ptr` is always a multiple of `ROWS_PER_BANK_CMD`.
- R8: The owed count never exceeds `MAX_OWED`. When it equals `MAX_OWED` and the rank is idle, a refresh starts on that edge even with `ref_gnt` at 0.
- R9: `ref_gnt` has no effect in a cycle where `ref_req` is 0. `rank_busy` stays 0 and the pointer holds.
- R10: If refreshes are still owed when a busy period ends, `ref_req` reads 1 in the cycle right after `rank_busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_gnt | input | 1 | Grant from the command scheduler; counts only while `ref_req` is 1 |
| ref_req | output | 1 | A refresh is owed and the rank is idle |
| rank_busy | output | 1 | The rank is refreshing and cannot take accesses |
| row_ptr | output | $clog2(BANK_ROWS) | First row, in every bank, of the next group to refresh |

## Verification
If the owed count is wrong, it shows at the ports within one cycle. A lost owed refresh drops `ref_req` too early after a busy period. An extra one keeps `ref_req` high, or forces a refresh one interval early. A wrong busy counter changes the length of `rank_busy` on the very next refresh. A wrong pointer shows as a bad step or a missed wrap when `rank_busy` falls. A small configuration is swept through many grant patterns, with an arithmetic model compared every cycle, so any of these errors is reported within one refresh interval.

// File: rtl/rfsh_pkg.sv
// Shared types for the refresh scheduler.
// Assumes: nothing beyond a synthesizable SystemVerilog flow.
package rfsh_pkg;

    // Phase of the busy window.
    typedef enum logic {
        WIN_IDLE   = 1'b0,
        WIN_ACTIVE = 1'b1
    } win_state_e;

endpackage

// File: rtl/rfsh_tick_timer.sv
// Interval timer: pulses tick_o once every INTERVAL_CYC cycles.
// The first pulse comes on the INTERVAL_CYC-th edge after reset release.
// Assumes INTERVAL_CYC >= 2.
module rfsh_tick_timer #(
    parameter int INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int TW = $clog2(INTERVAL_CYC);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

    logic [TW-1:0] cnt_q;

    // Decode the last count of the interval.
    always_comb tick_o = (cnt_q == LAST);

    // Free-running count that restarts after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R2

    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/rfsh_owed_counter.sv
// Owed-refresh counter: adds a tick, removes a started refresh.
// Raises the request while refreshes are owed and the rank is idle.
// Starts a refresh on a grant, or without one once MAX_OWED is reached.
// Assumes the interval exceeds the busy time plus one cycle, so at most
// one tick lands inside any busy window.
module rfsh_owed_counter #(
    parameter int MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic gnt_i,
    input  logic idle_i,
    output logic req_o,
    output logic start_o
);
    localparam int PW = $clog2(MAX_OWED + 1);
    localparam logic [PW-1:0] CEIL = PW'(MAX_OWED);

    logic [PW-1:0] owed_q;
    logic          owed_full;

    // Request and start decisions.
    always_comb begin
        owed_full = (owed_q == CEIL);
        req_o     = (owed_q != '0) && idle_i;
        start_o   = req_o && (gnt_i || owed_full);
    end

    // Owed count: a tick adds one, a start removes one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else begin
            case ({tick_i, start_o})
                2'b10:   owed_q <= owed_q + 1'b1;
                2'b01:   owed_q <= owed_q - 1'b1;
                default: owed_q <= owed_q;
            endcase
        end
    end

    AST_OWED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        owed_q <= CEIL); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(owed_full && tick_i && !start_o)); // R8
endmodule

// File: rtl/rfsh_busy_window.sv
// Busy window: after a start, holds busy_o for exactly BUSY_CYC cycles.
// done_o pulses in the last busy cycle.
// Assumes no start arrives while the window is active.
module rfsh_busy_window
    import rfsh_pkg::*;
#(
    parameter int BUSY_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int BW = $clog2(BUSY_CYC + 1);
    localparam logic [BW-1:0] LOAD = BW'(BUSY_CYC - 1);

    win_state_e    st_q;
    logic [BW-1:0] left_q;

    // Busy flag and last-cycle decode.
    always_comb begin
        busy_o = (st_q == WIN_ACTIVE);
        done_o = busy_o && (left_q == '0);
    end

    // Window state and remaining-cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WIN_IDLE;
            left_q <= '0;
        end else if (start_i) begin
            st_q   <= WIN_ACTIVE;
            left_q <= LOAD;
        end else if (done_o) begin
            st_q   <= WIN_IDLE;
        end else if (busy_o) begin
            left_q <= left_q - 1'b1;
        end
    end

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o); // R4

    AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= LOAD); // R4
endmodule

// File: rtl/rfsh_row_pointer.sv
// Row group pointer: advances by STEP rows when a refresh completes and
// wraps to zero after the last group. A power-of-two row count uses
// natural wrap; any other count compares against the last group.
// Assumes TOTAL_ROWS is a multiple of STEP.
module rfsh_row_pointer #(
    parameter int TOTAL_ROWS = 65536,
    parameter int STEP       = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          adv_i,
    output logic [$clog2(TOTAL_ROWS)-1:0] ptr_o
);
    localparam int AW = $clog2(TOTAL_ROWS);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);
    localparam logic [AW-1:0] LAST_GRP = AW'(TOTAL_ROWS - STEP);
    localparam bit POW2 = ((1 << AW) == TOTAL_ROWS);

    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_nxt;

    generate
        if (POW2) begin : g_natural_wrap
            // Modulo arithmetic wraps on its own.
            always_comb ptr_nxt = ptr_q + STEP_V;
        end else begin : g_compare_wrap
            // Explicit return to zero after the last group.
            always_comb ptr_nxt = (ptr_q == LAST_GRP) ? '0 : ptr_q + STEP_V;
        end
    endgenerate

    // Pointer register, moved only on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv_i) begin
            ptr_q <= ptr_nxt;
        end
    end

    always_comb ptr_o = ptr_q;

    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ptr_q) % STEP) == 0); // R7

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST_GRP); // R7
endmodule

// File: rtl/rfsh_sched.sv
// Refresh scheduler for one DRAM rank. Owes one refresh per interval,
// asks the command scheduler for it, and marks the rank busy while a
// group of rows is refreshed in every bank at once. The row pointer
// moves on one group at the end of each busy window. Refresh is forced
// once MAX_OWED refreshes are owed.
// Assumes REF_INTERVAL_CYC > busy time + 1 and BANK_ROWS is a multiple
// of ROWS_PER_BANK_CMD.
module rfsh_sched #(
    parameter int REF_INTERVAL_CYC  = 1560,
    parameter int ROW_REF_CYC       = 8,
    parameter int ROWS_PER_BANK_CMD = 8,
    parameter int BANK_ROWS         = 65536,
    parameter int MAX_OWED          = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ref_gnt,
    output logic                         ref_req,
    output logic                         rank_busy,
    output logic [$clog2(BANK_ROWS)-1:0] row_ptr
);
    localparam int BUSY_CYC = ROWS_PER_BANK_CMD * ROW_REF_CYC;

    initial begin
        AST_PARAMS_OK: assert (REF_INTERVAL_CYC > BUSY_CYC + 1
                               && (BANK_ROWS % ROWS_PER_BANK_CMD) == 0
                               && MAX_OWED >= 1); // R8
    end

    logic tick;
    logic start;
    logic done;
    logic busy;

    rfsh_tick_timer #(
        .INTERVAL_CYC (REF_INTERVAL_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rfsh_owed_counter #(
        .MAX_OWED (MAX_OWED)
    ) u_owed (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .gnt_i   (ref_gnt),
        .idle_i  (!busy),
        .req_o   (ref_req),
        .start_o (start)
    );

    rfsh_busy_window #(
        .BUSY_CYC (BUSY_CYC)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy),
        .done_o  (done)
    );

    rfsh_row_pointer #(
        .TOTAL_ROWS (BANK_ROWS),
        .STEP       (ROWS_PER_BANK_CMD)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (done),
        .ptr_o (row_ptr)
    );

    always_comb rank_busy = busy;

    AST_REQ_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rank_busy |-> !ref_req); // R5

    AST_BUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=> rank_busy); // R4

    AST_GNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_req && !rank_busy && ref_gnt && !start) |=> !rank_busy); // R9

    AST_PTR_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (row_ptr != $past(row_ptr)) |-> $fell(rank_busy)); // R6
endmodule

// File: tb/rfsh_sched_test.sv
`timescale 1ns/1ps
// Bench for rfsh_sched on a small configuration: the outputs are compared
// every cycle with an arithmetic model, plus directed checks.
module rfsh_sched_test;
    localparam int INTERVAL = 20;
    localparam int ROWCYC   = 2;
    localparam int STEP     = 2;
    localparam int TOTAL    = 8;
    localparam int MAXO     = 3;
    localparam int BUSY     = STEP * ROWCYC;
    localparam int AW       = $clog2(TOTAL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gnt = 1'b0;
    logic          ref_req;
    logic          rank_busy;
    logic [AW-1:0] row_ptr;

    int total = 0;
    int bad = 0;
    bit cmp_on = 1'b0;
    int wraps = 0;

    // Model state
    int m_t = 0;
    int m_owed = 0;
    int m_left = 0;
    int m_ptr = 0;

    rfsh_sched #(
        .REF_INTERVAL_CYC  (INTERVAL),
        .ROW_REF_CYC       (ROWCYC),
        .ROWS_PER_BANK_CMD (STEP),
        .BANK_ROWS         (TOTAL),
        .MAX_OWED          (MAXO)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_gnt   (gnt),
        .ref_req   (ref_req),
        .rank_busy (rank_busy),
        .row_ptr   (row_ptr)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Model built from the requirement text.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_t <= 0; m_owed <= 0; m_left <= 0; m_ptr <= 0;
        end else begin
            automatic bit tk = (m_t == INTERVAL - 1);
            automatic bit st = (m_left == 0) && (m_owed != 0) && (gnt || m_owed == MAXO);
            m_t    <= tk ? 0 : m_t + 1;
            m_owed <= m_owed + int'(tk) - int'(st);
            if (st) m_left <= BUSY;
            else if (m_left != 0) begin
                m_left <= m_left - 1;
                if (m_left == 1) m_ptr <= (m_ptr + STEP) % TOTAL;
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    logic [AW-1:0] prev_ptr = '0;
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R3 ref_req vs model", int'(ref_req), int'(m_owed != 0 && m_left == 0));
            chk("R4 rank_busy vs model", int'(rank_busy), int'(m_left != 0));
            chk("R6 row_ptr vs model", int'(row_ptr), m_ptr);
            if (rank_busy) chk("R5 no request while busy", int'(ref_req), 0);
            if (int'(prev_ptr) == TOTAL - STEP && row_ptr == '0) wraps++;
        end
        prev_ptr <= row_ptr;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=expired exp=finished");
        finish_run();
    end

    initial begin
        int n;
        bit seen;
        repeat (4) @(negedge clk);
        chk("R1 reset ref_req", int'(ref_req), 0);
        chk("R1 reset rank_busy", int'(rank_busy), 0);
        chk("R1 reset row_ptr", int'(row_ptr), 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        chk("R1 first cycle ref_req", int'(ref_req), 0);

        // R9: grants before anything is owed do nothing.
        gnt = 1'b1;
        seen = 1'b0;
        for (int i = 2; i < INTERVAL; i++) begin
            @(negedge clk);
            if (rank_busy || ref_req) seen = 1'b1;
        end
        gnt = 1'b0;
        chk("R9 grant without request ignored", int'(seen), 0);
        chk("R9 pointer held", int'(row_ptr), 0);
        @(negedge clk);
        chk("R2 first request after interval", int'(ref_req), 1);

        // R3: request held without grant.
        repeat (5) @(negedge clk);
        chk("R3 request held", int'(ref_req), 1);

        // R4, R6: one granted refresh.
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        n = 0;
        while (rank_busy && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R4 busy length", n, BUSY);
        chk("R6 pointer step", int'(row_ptr), STEP);

        // Sweep of grant patterns.
        for (int k = 1; k <= 6; k++) begin
            for (int c = 0; c < INTERVAL * 4; c++) begin
                @(negedge clk);
                gnt = ((c % k) == 0);
            end
        end
        gnt = 1'b0;
        chk("R7 wrap seen", int'(wraps > 0), 1);

        // R8: with no grants the refresh is forced at the ceiling.
        seen = 1'b0;
        for (int i = 0; i < INTERVAL * (MAXO + 2); i++) begin
            @(negedge clk);
            if (rank_busy) begin seen = 1'b1; break; end
        end
        chk("R8 forced refresh without grant", int'(seen), 1);
        while (rank_busy) @(negedge clk);
        chk("R10 request right after busy", int'(ref_req), 1);

        // Drain with grants held.
        gnt = 1'b1;
        repeat (INTERVAL * 3) @(negedge clk);
        gnt = 1'b0;
        repeat (BUSY + 2) @(negedge clk);
        chk("R3 drained", int'(ref_req), 0);
        cmp_on = 1'b0;
        finish_run();
    end
endmodule